// File: doc/BRIEF.md
# Cascadable Serial DAC Input Register

This block is the digital front end of a serially loaded 14-bit converter. A host drives three wires: a serial clock, a serial data line and an active-low select/load strobe. While the strobe is low, each low-to-high transition of the serial clock shifts one data bit into a 16-bit shift register, most significant bit first. When the strobe returns high, the leading 14 bits of the shift register are copied into a holding register. That register drives the parallel code of the converter core directly. The last bit of the shift register is presented on a cascade output, so several devices can be chained data-out to data-in and share clock and strobe.

The serial inputs are asynchronous to the block's system clock. They are brought into that domain through a synchroniser, and the rest of the logic runs on the system clock. A small control machine tracks the strobe and the synchronised serial clock. It has four states. ST_IDLE means the strobe is high. ST_WAIT_LOW means the strobe is low but the serial clock was already high when it fell, so that edge must not count. ST_READY means the strobe is low, the clock is low and the machine is armed for a rising edge. ST_HIGH means a rising edge has been taken and the machine waits for the clock to fall. The transitions are:
- IDLE to WAIT_LOW on a strobe fall with the clock high.
- IDLE to READY on a strobe fall with the clock low.
- WAIT_LOW to READY when the clock falls.
- READY to HIGH on a clock rise, which issues one shift.
- HIGH to READY when the clock falls.
- From WAIT_LOW, READY or HIGH back to IDLE when the strobe rises, which issues one load.

A power-on reset clears both registers.

Top module: `serial_dac_frontend`

## Requirements
- R1: While reset is asserted and after it is released, code_o is 0 and sdo_o is 0 until data is shifted.
- R2: With sel_n_i low, each low-to-high transition of sclk_i shifts sdi_i into the 16-bit shift register at bit 0, exactly one bit per transition. After a 16-bit frame and a rise of sel_n_i, code_o bit 13 holds the first bit sent and bit 0 holds the fourteenth.
- R3: Transitions of sclk_i while sel_n_i is high leave the shift register unchanged. Lowering and raising sel_n_i again with no clocks reloads the same code.
- R4: code_o changes only in response to a rise of sel_n_i and holds its value while a frame is being shifted.
- R5: The 15th and 16th bits of a 16-bit frame do not affect code_o.
- R6: sdo_o shows shift-register bit 15. Before the k-th rising clock of a frame it equals bit k-1 of the previous frame, counted from the first bit sent.
- R7: If sclk_i is already high when sel_n_i falls, that high level causes no shift. The first shift is the next low-to-high transition.
- R8: When sel_n_i rises after fewer or more than 16 clocks, code_o is loaded from shift-register bits 15 to 2 as they stand, with no error indication.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low power-on reset, asynchronous assert |
| sclk_i | input | 1 | Serial clock, asynchronous to clk |
| sdi_i | input | 1 | Serial data, sampled on serial clock rise |
| sel_n_i | input | 1 | Active-low select; its rise loads the code |
| sdo_o | output | 1 | Cascade data out, shift-register bit 15 |
| code_o | output | 14 | Parallel code to the converter core |

## Verification
The assertions take for granted that the serial clock, data and strobe each stay at one level for several system-clock cycles. Each edge is then seen once after the synchroniser. They also assume that data is steady around every serial clock rise, so the sampled bit is the intended one. The stimulus holds every serial level for six system cycles, well beyond the synchroniser depth. It changes data only while the serial clock is low, and it moves the strobe only half a serial period away from a clock edge. The one deliberate violation of the usual ordering is the test that lowers the strobe with the clock held high, and that case has its own check.

// File: rtl/sdr_pkg.sv
package sdr_pkg;
    typedef enum logic [1:0] {
        ST_IDLE     = 2'd0,
        ST_WAIT_LOW = 2'd1,
        ST_READY    = 2'd2,
        ST_HIGH     = 2'd3
    } ctl_state_t;
endpackage

// File: rtl/sdr_sync.sv
module sdr_sync #(
    parameter int W      = 3,
    parameter int STAGES = 2,
    parameter logic [W-1:0] RST_VAL = '0
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] d_i,
    output logic [W-1:0] q_o
);
    logic [STAGES-1:0][W-1:0] stg_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i < STAGES; i++) stg_q[i] <= RST_VAL;
        end else begin
            stg_q[0] <= d_i;
            for (int i = 1; i < STAGES; i++) stg_q[i] <= stg_q[i-1];
        end
    end

    assign q_o = stg_q[STAGES-1];
endmodule

// File: rtl/sdr_ctl.sv
module sdr_ctl
    import sdr_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic sclk_s,
    input  logic sel_n_s,
    output logic shift_o,
    output logic load_o
);
    ctl_state_t state_q, state_d;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: begin
                if (!sel_n_s) state_d = sclk_s ? ST_WAIT_LOW : ST_READY;
            end
            ST_WAIT_LOW: begin
                if (sel_n_s)      state_d = ST_IDLE;
                else if (!sclk_s) state_d = ST_READY;
            end
            ST_READY: begin
                if (sel_n_s)     state_d = ST_IDLE;
                else if (sclk_s) state_d = ST_HIGH;
            end
            ST_HIGH: begin
                if (sel_n_s)      state_d = ST_IDLE;
                else if (!sclk_s) state_d = ST_READY;
            end
            default: state_d = ST_IDLE;
        endcase
    end

    always_comb begin
        shift_o = 1'b0;
        load_o  = 1'b0;
        unique case (state_q)
            ST_IDLE:     ;
            ST_WAIT_LOW: load_o = sel_n_s;
            ST_READY: begin
                load_o  = sel_n_s;
                shift_o = !sel_n_s && sclk_s;
            end
            ST_HIGH:     load_o = sel_n_s;
            default:     ;
        endcase
    end

    // R2
    one_shift_per_edge_chk: assert property (@(posedge clk) disable iff (!rst_n)
        shift_o |-> $rose(sclk_s));

    // R7
    no_shift_on_high_at_select_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ($fell(sel_n_s) && sclk_s) |=> !shift_o);
endmodule

// File: rtl/sdr_shift.sv
module sdr_shift #(
    parameter int FRAME_W = 16
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               shift_i,
    input  logic               bit_i,
    output logic [FRAME_W-1:0] frame_o,
    output logic               sdo_o
);
    logic [FRAME_W-1:0] sr_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)       sr_q <= '0;
        else if (shift_i) sr_q <= {sr_q[FRAME_W-2:0], bit_i};
    end

    assign frame_o = sr_q;
    assign sdo_o   = sr_q[FRAME_W-1];

    // R3
    shift_reg_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !shift_i |=> $stable(sr_q));
endmodule

// File: rtl/sdr_hold.sv
module sdr_hold #(
    parameter int FRAME_W = 16,
    parameter int CODE_W  = 14
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               load_i,
    input  logic [FRAME_W-1:0] frame_i,
    output logic [CODE_W-1:0]  code_o
);
    logic [CODE_W-1:0] code_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)      code_q <= '0;
        else if (load_i) code_q <= frame_i[FRAME_W-1 -: CODE_W];
    end

    assign code_o = code_q;

    // R4
    code_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !load_i |=> $stable(code_q));
endmodule

// File: rtl/serial_dac_frontend.sv
module serial_dac_frontend #(
    parameter int CODE_W      = 14,
    parameter int PAD_W       = 2,
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              sclk_i,
    input  logic              sdi_i,
    input  logic              sel_n_i,
    output logic              sdo_o,
    output logic [CODE_W-1:0] code_o
);
    localparam int FRAME_W = CODE_W + PAD_W;

    logic [2:0]         sync_q;
    logic               sel_n_s, sclk_s, sdi_s;
    logic               shift_en, load_en;
    logic [FRAME_W-1:0] frame;

    sdr_sync #(.W(3), .STAGES(SYNC_STAGES), .RST_VAL(3'b100)) u_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .d_i   ({sel_n_i, sclk_i, sdi_i}),
        .q_o   (sync_q)
    );

    assign sel_n_s = sync_q[2];
    assign sclk_s  = sync_q[1];
    assign sdi_s   = sync_q[0];

    sdr_ctl u_ctl (
        .clk     (clk),
        .rst_n   (rst_n),
        .sclk_s  (sclk_s),
        .sel_n_s (sel_n_s),
        .shift_o (shift_en),
        .load_o  (load_en)
    );

    sdr_shift #(.FRAME_W(FRAME_W)) u_shift (
        .clk     (clk),
        .rst_n   (rst_n),
        .shift_i (shift_en),
        .bit_i   (sdi_s),
        .frame_o (frame),
        .sdo_o   (sdo_o)
    );

    sdr_hold #(.FRAME_W(FRAME_W), .CODE_W(CODE_W)) u_hold (
        .clk     (clk),
        .rst_n   (rst_n),
        .load_i  (load_en),
        .frame_i (frame),
        .code_o  (code_o)
    );

    // R8
    load_on_select_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(sel_n_s) |-> load_en);

    // R2
    no_shift_while_deselected_chk: assert property (@(posedge clk) disable iff (!rst_n)
        sel_n_s |-> !shift_en);
endmodule

// File: tb/tb_serial_dac_frontend.sv
`timescale 1ns/1ps
module tb_serial_dac_frontend;
    localparam int HP = 6;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        sclk = 1'b0, sdi = 1'b0, sel_n = 1'b1;
    logic        sdo;
    logic [13:0] code;

    int errors = 0;
    int checks = 0;
    bit done = 1'b0;
    logic [15:0] mdl = '0;

    always #2.5 clk = ~clk;

    serial_dac_frontend dut (
        .clk(clk), .rst_n(rst_n), .sclk_i(sclk), .sdi_i(sdi),
        .sel_n_i(sel_n), .sdo_o(sdo), .code_o(code)
    );

    task automatic wait_cyc(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic check(input string tag, input logic [15:0] act, input logic [15:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic send_bit(input logic b);
        sdi = b;
        wait_cyc(HP);
        // R6: cascade output shows bit 15 before the shift
        check("R6 sdo", {15'd0, sdo}, {15'd0, mdl[15]});
        sclk = 1'b1;
        if (!sel_n) mdl = {mdl[14:0], b};
        wait_cyc(HP);
        sclk = 1'b0;
    endtask

    task automatic sel_fall();
        sel_n = 1'b0;
        wait_cyc(HP);
    endtask

    task automatic sel_rise(input string tag);
        sel_n = 1'b1;
        wait_cyc(HP);
        check(tag, {2'b00, code}, {2'b00, mdl[15:2]});
    endtask

    task automatic send_frame(input logic [13:0] c, input logic [1:0] pad, input string tag);
        logic [15:0] w;
        w = {c, pad};
        sel_fall();
        for (int i = 15; i >= 0; i--) send_bit(w[i]);
        sel_rise(tag);
        check({tag, " code"}, {2'b00, code}, {2'b00, c});
    endtask

    initial begin : watchdog
        int n;
        n = 0;
        while (!done && n < 150000) begin
            @(posedge clk);
            n++;
        end
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog: actual=timeout expected=finish");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin : main
        logic [13:0] prev;
        wait_cyc(4);
        // R1
        check("R1 code in reset", {2'b00, code}, 16'd0);
        check("R1 sdo in reset", {15'd0, sdo}, 16'd0);
        rst_n = 1'b1;
        wait_cyc(4);
        check("R1 code after reset", {2'b00, code}, 16'd0);
        check("R1 sdo after reset", {15'd0, sdo}, 16'd0);

        // R2: sweep of codes
        send_frame(14'h0000, 2'b00, "R2 zeros");
        send_frame(14'h3FFF, 2'b11, "R2 ones");
        for (int k = 0; k < 14; k++)
            send_frame(14'(1 << k), 2'b01, "R2 walking one");
        for (int k = 0; k < 20; k++)
            send_frame(14'((k * 1237 + 91) % 16384), 2'(k), "R2 arith");

        // R5: dummy bits ignored
        for (int p = 0; p < 4; p++)
            send_frame(14'h2A5C, 2'(p), "R5 pad variant");

        // R4: code holds mid-frame
        prev = code;
        sel_fall();
        for (int i = 0; i < 8; i++) send_bit(i[0]);
        check("R4 hold mid-frame", {2'b00, code}, {2'b00, prev});
        for (int i = 0; i < 8; i++) send_bit(~i[0]);
        check("R4 hold before load", {2'b00, code}, {2'b00, prev});
        sel_rise("R4 load on rise");

        // R3: clocks while deselected are ignored
        send_frame(14'h1234, 2'b10, "R3 setup");
        for (int i = 0; i < 5; i++) send_bit(1'b1);
        sel_fall();
        sel_rise("R3 reload unchanged");
        check("R3 code value", {2'b00, code}, {2'b00, 14'h1234});

        // R7: clock already high at select fall
        sclk = 1'b1;
        sdi  = 1'b1;
        wait_cyc(HP);
        sel_n = 1'b0;
        wait_cyc(HP);
        sclk = 1'b0;
        wait_cyc(HP);
        for (int i = 15; i >= 0; i--) send_bit(((16'h0F0F) >> i) & 1'b1);
        sel_rise("R7 no extra shift");
        check("R7 code value", {2'b00, code}, {2'b00, 14'h03C3});

        // R8: short and long frames
        sel_fall();
        for (int i = 0; i < 8; i++) send_bit(1'b1);
        sel_rise("R8 short frame");
        sel_fall();
        for (int i = 0; i < 20; i++) send_bit(i[1]);
        sel_rise("R8 long frame");
        sel_fall();
        sel_rise("R8 empty frame");

        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule